// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a 16-bit tick counter on a small register bus. It has two uses. In watchdog mode it asks for a system reset when software fails to clear it in time. In interval mode it raises a periodic interrupt.

Software sets the block up through one control word. A write to that word is accepted only when its upper byte carries a fixed key. The control word selects:
- the tick source, either a fast system tick or a slow auxiliary tick;
- one of four expiry lengths;
- the mode;
- a hold that freezes the count.

The control word also has a self-clearing bit that zeroes the counter. Two separate byte registers hold the interrupt enable and the interrupt flag. The interrupt output is the AND of the two.

Any expiry in watchdog mode produces a one-cycle reset request. So does any control write with a wrong key. The reset request also returns the control word to its default: watchdog mode, fast tick, 32768-tick interval, not held.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset, a read of the control word at address 0x0120 returns 0x6900. The enable register (0x0000), the flag register (0x0002), the reset request and the interrupt output are all 0.
- R2: A write to 0x0120 whose upper byte is 0x5A stores bits 7:4 and 2:0 of the lower byte. Reads of 0x0120 return 0x69 in the upper byte and the stored lower byte, with bit 3 always read as 0.
- R3: A write to 0x0120 whose upper byte is not 0x5A pulses the reset request for one cycle, starting in the cycle after the write. The stored configuration is not updated from the written data and is returned to the default (read 0x6900).
- R4: Control bits 1:0 select the expiry length. The values 00, 01, 10 and 11 give 32768, 8192, 512 and 64 ticks. Expiry happens on the Nth counted tick after the counter is cleared.
- R5: Control bit 2 selects the tick source: 0 counts the fast tick, 1 counts the slow tick. The tick that is not selected is ignored.
- R6: Writing control bit 3 as 1 with a valid key zeroes the counter. A clear write and a tick in the same cycle leave the counter at 0.
- R7: When control bit 4 is 0, expiry produces a one-cycle reset request and returns the control word to its default. The same pulse starts the default 32768-tick watchdog period from zero.
- R8: When control bit 4 is 1, expiry sets the flag at bit 0 of 0x0002, and the counter keeps running, so the next expiry comes N ticks later.
- R9: While control bit 7 is 1, the counter does not advance and no expiry occurs.
- R10: The interrupt output equals the flag ANDed with the enable, which is bit 0 of 0x0000.
- R11: Writing bit 0 of 0x0002 sets the flag to the written value. An interval expiry in the same cycle as a write of 0 leaves the flag set.
- R12: Control bits 5 and 6 are stored and read back but do not change counting, expiry or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| tick_fast | input | 1 | Fast system tick enable |
| tick_slow | input | 1 | Slow auxiliary tick enable |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Interrupt output, flag AND enable |

## Verification
Read data is combinational, so the bench reads it a short delay after setting the address, within the same cycle.

A register write, a flag change or the reset request becomes visible after the single clock edge that samples the write or the expiring tick. After a clearing write, the Nth counted tick lands on the Nth following edge. The bench therefore checks the flag or the reset request one edge before that point (still clear) and at that point (set).

With a sparse slow tick, the bench counts the ticks it has applied instead of counting cycles. All sampling happens at the falling edge.

// File: rtl/pwd_watchdog.sv
module pwd_watchdog #(
  parameter int              AW        = 16,
  parameter int              CNT_W     = 16,
  parameter int              TAP0      = 15,
  parameter int              TAP1      = 13,
  parameter int              TAP2      = 9,
  parameter int              TAP3      = 6,
  parameter logic [AW-1:0]   CTRL_ADDR = 16'h0120,
  parameter logic [AW-1:0]   IEN_ADDR  = 16'h0000,
  parameter logic [AW-1:0]   IFLG_ADDR = 16'h0002,
  parameter logic [7:0]      WR_KEY    = 8'h5A,
  parameter logic [7:0]      RD_KEY    = 8'h69
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic          tick_fast,
  input  logic          tick_slow,
  output logic          rst_req,
  output logic          irq
);

  localparam logic [CNT_W-1:0] MSK0 = CNT_W'((1 << TAP0) - 1);
  localparam logic [CNT_W-1:0] MSK1 = CNT_W'((1 << TAP1) - 1);
  localparam logic [CNT_W-1:0] MSK2 = CNT_W'((1 << TAP2) - 1);
  localparam logic [CNT_W-1:0] MSK3 = CNT_W'((1 << TAP3) - 1);

  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tap_mask;
  logic             ien, iflg;

  wire ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  wire key_ok  = (bus_wdata[15:8] == WR_KEY);
  wire good_wr = ctrl_wr && key_ok;
  wire bad_wr  = ctrl_wr && !key_ok;

  always_comb begin
    case (ctrl_q[1:0])
      2'd0:    tap_mask = MSK0;
      2'd1:    tap_mask = MSK1;
      2'd2:    tap_mask = MSK2;
      default: tap_mask = MSK3;
    endcase
  end

  wire tick    = ctrl_q[2] ? tick_slow : tick_fast;
  wire run     = tick && !ctrl_q[7];
  wire hit     = run && ((cnt & tap_mask) == tap_mask);
  wire wd_trip = (hit && !ctrl_q[4]) || bad_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wd_trip;
      if (wd_trip) begin
        ctrl_q <= '0;
        cnt    <= '0;
      end else begin
        if (good_wr) ctrl_q <= {bus_wdata[7:4], 1'b0, bus_wdata[2:0]};
        if (good_wr && bus_wdata[3]) cnt <= '0;
        else if (run)                cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= 1'b0;
      iflg <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == IEN_ADDR) ien <= bus_wdata[0];
      if (hit && ctrl_q[4])                    iflg <= 1'b1;
      else if (bus_wr && bus_addr == IFLG_ADDR) iflg <= bus_wdata[0];
    end
  end

  assign irq = ien & iflg;

  always_comb begin
    case (bus_addr)
      CTRL_ADDR: bus_rdata = {RD_KEY, ctrl_q};
      IEN_ADDR:  bus_rdata = {15'd0, ien};
      IFLG_ADDR: bus_rdata = {15'd0, iflg};
      default:   bus_rdata = 16'd0;
    endcase
  end

endmodule

module pwd_watchdog_chk #(
  parameter int            AW        = 16,
  parameter int            CNT_W     = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h0120,
  parameter logic [AW-1:0] IEN_ADDR  = 16'h0000,
  parameter logic [7:0]    WR_KEY    = 8'h5A
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [15:0]      bus_wdata,
  input logic             rst_req,
  input logic             irq,
  input logic [7:0]       ctrl_q,
  input logic [CNT_W-1:0] cnt,
  input logic             hit,
  input logic             iflg
);

  assert_badkey_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[15:8] != WR_KEY) |=> rst_req);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[15:8] == WR_KEY && bus_wdata[3]) |=> (cnt == '0));

  assert_default_on_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctrl_q == 8'h00));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl_q[4]) |=> iflg);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && !bus_wr) |=> $stable(cnt));

  assert_enable_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == IEN_ADDR && !bus_wdata[0]) |=> !irq);

endmodule

bind pwd_watchdog pwd_watchdog_chk #(
  .AW(AW), .CNT_W(CNT_W), .CTRL_ADDR(CTRL_ADDR), .IEN_ADDR(IEN_ADDR), .WR_KEY(WR_KEY)
) u_chk (.*);

// File: tb/sim_pwd_watchdog.sv
module sim_pwd_watchdog;
  localparam int CLK_P = 10;
  localparam logic [15:0] A_CTRL = 16'h0120;
  localparam logic [15:0] A_IEN  = 16'h0000;
  localparam logic [15:0] A_IFLG = 16'h0002;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick_fast = 1'b1;
  logic        tick_slow = 1'b0;
  logic        rst_req, irq;

  int checks = 0;
  int fails  = 0;

  pwd_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .rst_req(rst_req), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic flag_is(input string req, input int exp);
    logic [15:0] v;
    rd(A_IFLG, v);
    chk(req, int'(v), exp);
  endtask

  task automatic run_interval(input int sel);
    int n;
    n = 1 << ((sel == 0) ? 15 : (sel == 1) ? 13 : (sel == 2) ? 9 : 6);
    wr(A_IFLG, 16'h0000);
    wr(A_CTRL, 16'h5A18 | 16'(sel));
    for (int k = 1; k <= 2*n; k++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      if (k == n-1)   flag_is($sformatf("R4 tap %0d before first expiry", sel), 0);
      if (k == n) begin
        flag_is($sformatf("R4 tap %0d first expiry", sel), 1);
        bus_addr = A_IFLG; bus_wdata = 16'h0000; bus_wr = 1'b1;
      end
      if (k == 2*n-1) flag_is($sformatf("R8 tap %0d before second expiry", sel), 0);
      if (k == 2*n)   flag_is($sformatf("R8 tap %0d second expiry", sel), 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int applied;
    logic early;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(A_CTRL, v); chk("R1 ctrl", v, 16'h6900);
    rd(A_IEN, v);  chk("R1 ien", v, 0);
    rd(A_IFLG, v); chk("R1 iflg", v, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);
    rd(16'h0040, v); chk("R2 unmapped read", v, 0);

    wr(A_CTRL, 16'h5A7B);
    rd(A_CTRL, v); chk("R2 R12 readback", v, 16'h6973);
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      if (k == 63) flag_is("R12 no early expiry", 0);
      if (k == 64) flag_is("R12 expiry unaffected", 1);
    end

    for (int s = 3; s >= 0; s--) run_interval(s);

    wr(A_CTRL, 16'h1210);
    chk("R3 bad key request", rst_req, 1);
    rd(A_CTRL, v); chk("R3 default config", v, 16'h6900);
    @(negedge clk);
    chk("R3 one-cycle pulse", rst_req, 0);

    wr(A_IFLG, 16'h0000);
    wr(A_CTRL, 16'h5A1B);
    repeat (40) @(negedge clk);
    wr(A_CTRL, 16'h5A1B);
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      if (k == 24) flag_is("R6 old count discarded", 0);
      if (k == 63) flag_is("R6 before expiry", 0);
      if (k == 64) flag_is("R6 expiry after clear", 1);
    end

    wr(A_IFLG, 16'h0000);
    wr(A_CTRL, 16'h5A9B);
    repeat (200) @(negedge clk);
    flag_is("R9 held no expiry", 0);
    wr(A_CTRL, 16'h5A13);
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      if (k == 63) flag_is("R9 resume before expiry", 0);
      if (k == 64) flag_is("R9 resume expiry", 1);
    end

    wr(A_IFLG, 16'h0000);
    wr(A_CTRL, 16'h5A1F);
    applied = 0; early = 1'b0;
    for (int k = 1; k < 1000; k++) begin
      @(negedge clk);
      rd(A_IFLG, v);
      if (applied == 64) break;
      early |= v[0];
      tick_slow = (k % 3 == 0);
      if (tick_slow) applied++;
    end
    tick_slow = 1'b0;
    chk("R5 fast tick ignored", early, 0);
    chk("R5 slow expiry", v, 1);

    wr(A_IEN, 16'h0001);
    chk("R10 irq on", irq, 1);
    wr(A_IEN, 16'h0000);
    chk("R10 irq masked", irq, 0);
    wr(A_IEN, 16'h0001);
    wr(A_IFLG, 16'h0000);
    flag_is("R11 software clear", 0);
    chk("R10 irq clear", irq, 0);
    wr(A_IFLG, 16'h0001);
    wr(A_CTRL, 16'h5A1B);
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      if (k == 63) begin
        bus_addr = A_IFLG; bus_wdata = 16'h0000; bus_wr = 1'b1;
      end
    end
    flag_is("R11 expiry wins", 1);
    chk("R10 irq with expiry", irq, 1);
    wr(A_IFLG, 16'h0000);
    chk("R10 irq after clear", irq, 0);

    wr(A_CTRL, 16'h5A0B);
    for (int k = 1; k <= 65; k++) begin
      @(negedge clk);
      if (k == 63) chk("R7 no early request", rst_req, 0);
      if (k == 64) begin
        chk("R7 request", rst_req, 1);
        rd(A_CTRL, v); chk("R7 default restored", v, 16'h6900);
      end
      if (k == 65) chk("R7 pulse width", rst_req, 0);
    end
    for (int k = 66; k <= 64 + 32768; k++) begin
      @(negedge clk);
      if (k == 64 + 32767) chk("R7 default period early", rst_req, 0);
      if (k == 64 + 32768) chk("R7 default period", rst_req, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule